// File: doc/BRIEF.md
# Control-Word Steered 16-bit Arithmetic/Logic Unit

This block is the arithmetic and logic datapath of a small 16-bit processor. It has no opcode input. A separate decoder hands it a 12-bit control word. Each bit of that word turns on one piece of the datapath: an inverter on the source operand, two carry-in sources, five result units, two flag-update modes, a right-shift path and a write-suppress flag. Subtract and compare are therefore not operations of their own: they are the binary adder fed with an inverted source and a forced carry-in of one.

Each accepted operation takes the source and destination operands, a byte/word select and the current status flags. One clock later the block presents the registered result, the new flags, a flag-update enable and a destination write enable. In byte mode only the low half of each operand takes part, and the upper half of the result reads as zero.

Top module: `ctl_alu`

## Requirements
- R1: While `op_vld_i` is high, the result, flags, `flg_en_o` and `wr_o` of that operation appear on the outputs after the next rising clock edge.
- R2: Control bit 0 inverts the source operand before it reaches any unit, and control bit 1 forces an adder carry-in of one. Bits 0, 1 and 3 together give dst minus src, with carry set when no borrow occurs.
- R3: Control bit 2 adds the incoming carry flag (`flags_i[0]`) as carry-in to the binary and decimal adders.
- R4: Control bits 4, 5 and 6 select destination AND, OR and XOR of the possibly inverted source. Bit 3 selects the binary adder and bit 7 selects the decimal adder. At most one of bits 3 to 7 is set.
- R5: The flags are packed as {V,N,Z,C}, with C in bit 0. When control bit 9 is set, N is the result sign bit and Z is set when the result is zero. C is the carry out for the binary adder and for the decimal adder, the shifted-out bit for the shift path, and the inverse of Z otherwise. V is the adder signed overflow: both adder inputs have the same sign and the result sign differs.
- R6: When control bit 8 is set, N and Z are updated and C is set to the inverse of Z. If bit 9 is clear at the same time, V keeps its incoming value.
- R7: For the XOR unit with flags updated, V is set exactly when both original operands are negative.
- R8: When bits 8 and 9 are both clear, `flg_en_o` is low and `flags_o` equals the incoming `flags_i`.
- R9: Control bit 11 drives `wr_o` low. Flags are still updated as the flag bits request.
- R10: With `byte_i` high, only bits 7:0 take part. N comes from bit 7, Z from the low byte, and C and V from bit 7. Result bits 15:8 are zero.
- R11: The decimal adder treats the operands as four BCD digits (two in byte mode), adds them with a carry-in, and sets C on a decimal carry out of the top digit.
- R12: Control bit 10 selects a one-place right shift of the source. With bit 2 set, the incoming carry enters the MSB. With bit 2 clear, the MSB is kept. In both cases the old LSB becomes C.
- R13: When neither bit 10 nor any of bits 3 to 7 is set, the result is the (possibly inverted) source operand.
- R14: Reset clears all outputs. A cycle with `op_vld_i` low leaves `res_o` and `flags_o` unchanged and drives `wr_o` and `flg_en_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_vld_i | input | 1 | Operation present this cycle |
| ctl_i | input | 12 | Control word |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| byte_i | input | 1 | Byte-mode select |
| flags_i | input | 4 | Current flags {V,N,Z,C} |
| res_o | output | 16 | Registered result |
| flags_o | output | 4 | Registered flags {V,N,Z,C} |
| flg_en_o | output | 1 | Flags should be written back |
| wr_o | output | 1 | Destination should be written |

## Verification
The properties assume a well-formed control word: at most one result-unit bit among bits 3 to 7. They also assume that the decimal adder is given only digits 0 to 9. Every vector in the stimulus table obeys both rules; outside them the result is not defined. The only input left unconstrained is the idle-cycle garbage on the operand and flag pins, which must have no effect.

// File: rtl/ctl_alu_pkg.sv
package ctl_alu_pkg;
    localparam int CTL_W   = 12;
    // control word bit positions (fixed by the decoder)
    localparam int CB_INV  = 0;
    localparam int CB_INC  = 1;
    localparam int CB_INCC = 2;
    localparam int CB_ADD  = 3;
    localparam int CB_AND  = 4;
    localparam int CB_OR   = 5;
    localparam int CB_XOR  = 6;
    localparam int CB_DEC  = 7;
    localparam int CB_NZC  = 8;
    localparam int CB_ALL  = 9;
    localparam int CB_SHR  = 10;
    localparam int CB_NOWR = 11;
    // flag positions
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    typedef logic [3:0] flags_t;
endpackage

// File: rtl/alu_bin_add.sv
module alu_bin_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         co_half_o,
    output logic         co_full_o
);
    localparam int H = W / 2;

    logic [H:0]   lo_sum;
    logic [W-H:0] hi_sum;

    always_comb begin
        lo_sum    = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]} + {{H{1'b0}}, cin_i};
        hi_sum    = {1'b0, a_i[W-1:H]} + {1'b0, b_i[W-1:H]} + {{(W-H){1'b0}}, lo_sum[H]};
        sum_o     = {hi_sum[W-H-1:0], lo_sum[H-1:0]};
        co_half_o = lo_sum[H];
        co_full_o = hi_sum[W-H];
    end
endmodule

// File: rtl/alu_bcd_add.sv
module alu_bcd_add #(
    parameter int NDIG = 4
) (
    input  logic [4*NDIG-1:0] a_i,
    input  logic [4*NDIG-1:0] b_i,
    input  logic              cin_i,
    output logic [4*NDIG-1:0] sum_o,
    output logic              co_half_o,
    output logic              co_full_o
);
    logic [NDIG:0] cch;
    assign cch[0] = cin_i;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        logic [4:0] raw;
        logic       over;
        logic [4:0] adj;
        always_comb begin
            raw  = {1'b0, a_i[4*g +: 4]} + {1'b0, b_i[4*g +: 4]} + {4'd0, cch[g]};
            over = (raw > 5'd9);
            adj  = over ? (raw + 5'd6) : raw;
        end
        assign sum_o[4*g +: 4] = adj[3:0];
        assign cch[g+1]        = over;
    end

    assign co_half_o = cch[NDIG/2];
    assign co_full_o = cch[NDIG];
endmodule

// File: rtl/alu_shr.sv
module alu_shr #(
    parameter int W = 16
) (
    input  logic [W-1:0] val_i,
    input  logic         cfl_i,
    input  logic         rot_i,
    input  logic         byte_i,
    output logic [W-1:0] out_o,
    output logic         lsb_o
);
    localparam int H = W / 2;

    logic top_w;
    logic top_b;

    always_comb begin
        top_w = rot_i ? cfl_i : val_i[W-1];
        top_b = rot_i ? cfl_i : val_i[H-1];
        if (byte_i) out_o = {{(W-H){1'b0}}, top_b, val_i[H-1:1]};
        else        out_o = {top_w, val_i[W-1:1]};
        lsb_o = val_i[0];
    end
endmodule

// File: rtl/ctl_alu.sv
module ctl_alu
    import ctl_alu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             op_vld_i,
    input  logic [CTL_W-1:0] ctl_i,
    input  logic [DW-1:0]    src_i,
    input  logic [DW-1:0]    dst_i,
    input  logic             byte_i,
    input  logic [3:0]       flags_i,
    output logic [DW-1:0]    res_o,
    output logic [3:0]       flags_o,
    output logic             flg_en_o,
    output logic             wr_o
);
    localparam int H    = DW / 2;
    localparam int NDIG = DW / 4;

    typedef struct packed {
        logic [DW-1:0] res;
        flags_t        fl;
        logic          wr;
        logic          fen;
    } alu_st_t;

    alu_st_t st_d, st_q;

    logic [DW-1:0] op_b;
    logic          cin;
    logic [DW-1:0] add_sum, dec_sum, shr_out;
    logic          add_co_h, add_co_f, dec_co_h, dec_co_f, shr_lsb;

    assign op_b = ctl_i[CB_INV] ? ~src_i : src_i;
    assign cin  = ctl_i[CB_INC] | (ctl_i[CB_INCC] & flags_i[FL_C]);

    alu_bin_add #(.W(DW)) u_add (
        .a_i(dst_i), .b_i(op_b), .cin_i(cin),
        .sum_o(add_sum), .co_half_o(add_co_h), .co_full_o(add_co_f)
    );

    alu_bcd_add #(.NDIG(NDIG)) u_bcd (
        .a_i(dst_i), .b_i(op_b), .cin_i(cin),
        .sum_o(dec_sum), .co_half_o(dec_co_h), .co_full_o(dec_co_f)
    );

    alu_shr #(.W(DW)) u_shr (
        .val_i(op_b), .cfl_i(flags_i[FL_C]), .rot_i(ctl_i[CB_INCC]),
        .byte_i(byte_i), .out_o(shr_out), .lsb_o(shr_lsb)
    );

    logic [DW-1:0] unit_r, raw_r, res_m;
    logic          any_unit, upd, z, n, c, v, a_s, b_s, r_s;
    flags_t        fl_new;

    always_comb begin
        unit_r = ({DW{ctl_i[CB_ADD]}} & add_sum)
               | ({DW{ctl_i[CB_AND]}} & (dst_i & op_b))
               | ({DW{ctl_i[CB_OR]}}  & (dst_i | op_b))
               | ({DW{ctl_i[CB_XOR]}} & (dst_i ^ op_b))
               | ({DW{ctl_i[CB_DEC]}} & dec_sum);
        any_unit = |ctl_i[CB_DEC:CB_ADD];
        raw_r    = ctl_i[CB_SHR] ? shr_out : (any_unit ? unit_r : op_b);
        res_m    = byte_i ? {{(DW-H){1'b0}}, raw_r[H-1:0]} : raw_r;

        a_s = byte_i ? dst_i[H-1] : dst_i[DW-1];
        b_s = byte_i ? op_b[H-1]  : op_b[DW-1];
        r_s = byte_i ? res_m[H-1] : res_m[DW-1];
        z   = (res_m == '0);
        n   = r_s;

        if (ctl_i[CB_NZC])       c = ~z;
        else if (ctl_i[CB_SHR])  c = shr_lsb;
        else if (ctl_i[CB_ADD])  c = byte_i ? add_co_h : add_co_f;
        else if (ctl_i[CB_DEC])  c = byte_i ? dec_co_h : dec_co_f;
        else                     c = ~z;

        if (!ctl_i[CB_ALL])      v = flags_i[FL_V];
        else if (ctl_i[CB_SHR])  v = 1'b0;
        else if (ctl_i[CB_ADD])  v = (a_s == b_s) && (r_s != a_s);
        else if (ctl_i[CB_XOR])  v = byte_i ? (dst_i[H-1] & src_i[H-1])
                                            : (dst_i[DW-1] & src_i[DW-1]);
        else                     v = 1'b0;

        fl_new = '0;
        fl_new[FL_C] = c;
        fl_new[FL_Z] = z;
        fl_new[FL_N] = n;
        fl_new[FL_V] = v;
        upd = ctl_i[CB_NZC] | ctl_i[CB_ALL];

        st_d     = st_q;
        st_d.wr  = 1'b0;
        st_d.fen = 1'b0;
        if (op_vld_i) begin
            st_d.res = res_m;
            st_d.fl  = upd ? fl_new : flags_i;
            st_d.wr  = ~ctl_i[CB_NOWR];
            st_d.fen = upd;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign res_o    = st_q.res;
    assign flags_o  = st_q.fl;
    assign flg_en_o = st_q.fen;
    assign wr_o     = st_q.wr;
endmodule

// File: rtl/ctl_alu_chk.sv
module ctl_alu_chk #(
    parameter int DW = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          op_vld_i,
    input logic [11:0]   ctl_i,
    input logic          byte_i,
    input logic [3:0]    flags_i,
    input logic [DW-1:0] res_o,
    input logic [3:0]    flags_o,
    input logic          flg_en_o,
    input logic          wr_o
);
    // R10
    byte_upper_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_vld_i && byte_i |=> res_o[DW-1:DW/2] == '0);
    // R9
    wr_suppress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_vld_i && ctl_i[11] |=> !wr_o);
    // R8
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_vld_i && !ctl_i[8] && !ctl_i[9] |=> (flags_o == $past(flags_i)) && !flg_en_o);
    // R5
    zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flg_en_o |-> flags_o[1] == (res_o == '0));
    // R6
    nzc_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_vld_i && ctl_i[8] |=> flags_o[0] == !flags_o[1]);
    // R14
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !op_vld_i |=> !wr_o && !flg_en_o && $stable(res_o) && $stable(flags_o));
endmodule

bind ctl_alu ctl_alu_chk #(.DW(DW)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_vld_i(op_vld_i), .ctl_i(ctl_i),
    .byte_i(byte_i), .flags_i(flags_i), .res_o(res_o), .flags_o(flags_o),
    .flg_en_o(flg_en_o), .wr_o(wr_o)
);

// File: tb/ctl_alu_tb.sv
module ctl_alu_tb;
    localparam int CLK_P = 10;
    localparam int NV    = 23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic [11:0] ctl = '0;
    logic [15:0] src = '0, dst = '0;
    logic        bw = 1'b0;
    logic [3:0]  fin = '0;
    logic [15:0] res;
    logic [3:0]  fl;
    logic        fen, wr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    ctl_alu u_dut (
        .clk_i(clk), .rst_ni(rst_n), .op_vld_i(vld), .ctl_i(ctl),
        .src_i(src), .dst_i(dst), .byte_i(bw), .flags_i(fin),
        .res_o(res), .flags_o(fl), .flg_en_o(fen), .wr_o(wr)
    );

    // row: ctl, byte, flags_in, src, dst, exp res, exp flags {V,N,Z,C}, wr, fen, req
    localparam logic [78:0] VECS [0:NV-1] = '{
        {12'h208,1'b0,4'h0,16'h0001,16'h7fff,16'h8000,4'hC,1'b1,1'b1,8'd5},  // R5 overflow
        {12'h208,1'b0,4'h0,16'hffff,16'h0001,16'h0000,4'h3,1'b1,1'b1,8'd5},  // R5 carry
        {12'h20B,1'b0,4'h0,16'h0003,16'h0005,16'h0002,4'h1,1'b1,1'b1,8'd2},  // R2 sub
        {12'hA0B,1'b0,4'h0,16'h0005,16'h0003,16'hfffe,4'h4,1'b0,1'b1,8'd9},  // R9 compare
        {12'h20C,1'b0,4'h1,16'h0234,16'h1000,16'h1235,4'h0,1'b1,1'b1,8'd3},  // R3 add with carry
        {12'h208,1'b1,4'h0,16'h3401,16'h12ff,16'h0000,4'h3,1'b1,1'b1,8'd10}, // R10 byte carry
        {12'h208,1'b1,4'h0,16'h0001,16'h007f,16'h0080,4'hC,1'b1,1'b1,8'd10}, // R10 byte overflow
        {12'h310,1'b0,4'h0,16'h0ff0,16'hf0f0,16'h00f0,4'h1,1'b1,1'b1,8'd6},  // R6 and
        {12'hB10,1'b0,4'h0,16'hff00,16'h00ff,16'h0000,4'h2,1'b0,1'b1,8'd9},  // R9 bit test
        {12'h011,1'b0,4'hF,16'h00f0,16'hffff,16'hff0f,4'hF,1'b1,1'b0,8'd4},  // R4 bit clear
        {12'h020,1'b0,4'h5,16'h0034,16'h1200,16'h1234,4'h5,1'b1,1'b0,8'd8},  // R8 or, no flags
        {12'h240,1'b0,4'h0,16'h8003,16'h8001,16'h0002,4'h9,1'b1,1'b1,8'd7},  // R7 xor negatives
        {12'h240,1'b0,4'h0,16'h00ff,16'h00ff,16'h0000,4'h2,1'b1,1'b1,8'd7},  // R7 xor positives
        {12'h284,1'b0,4'h0,16'h0001,16'h0199,16'h0200,4'h0,1'b1,1'b1,8'd11}, // R11 digit ripple
        {12'h284,1'b0,4'h1,16'h0001,16'h9999,16'h0001,4'h1,1'b1,1'b1,8'd11}, // R11 overflow
        {12'h284,1'b1,4'h0,16'h0050,16'h1255,16'h0005,4'h1,1'b1,1'b1,8'd11}, // R11 byte
        {12'h604,1'b0,4'h1,16'h0001,16'h0000,16'h8000,4'h5,1'b1,1'b1,8'd12}, // R12 rotate
        {12'h600,1'b0,4'h0,16'h8002,16'h0000,16'hc001,4'h4,1'b1,1'b1,8'd12}, // R12 arith
        {12'h600,1'b1,4'h0,16'h1281,16'h0000,16'h00c0,4'h5,1'b1,1'b1,8'd12}, // R12 byte arith
        {12'h604,1'b1,4'h0,16'h0002,16'h0000,16'h0001,4'h0,1'b1,1'b1,8'd12}, // R12 byte rotate
        {12'h000,1'b0,4'h0,16'hbeef,16'h1111,16'hbeef,4'h0,1'b1,1'b0,8'd13}, // R13 move
        {12'h100,1'b0,4'h8,16'h0000,16'h0000,16'h0000,4'hA,1'b1,1'b1,8'd6},  // R6 V held
        {12'h000,1'b1,4'h0,16'habcd,16'h0000,16'h00cd,4'h0,1'b1,1'b0,8'd13}  // R13 byte move
    };

    task automatic check(input logic [21:0] got, input logic [21:0] exp, input int req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d: actual res=%h fl=%h wr=%b fen=%b expected res=%h fl=%h wr=%b fen=%b",
                     req, got[21:6], got[5:2], got[1], got[0], exp[21:6], exp[5:2], exp[1], exp[0]);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R14: watchdog expired, actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R14 reset state
        check({res, fl, wr, fen}, 22'd0, 14);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            vld = 1'b1;
            ctl = VECS[i][78:67];
            bw  = VECS[i][66];
            fin = VECS[i][65:62];
            src = VECS[i][61:46];
            dst = VECS[i][45:30];
            @(negedge clk);
            // R1 registered result one edge later
            check({res, fl, wr, fen}, VECS[i][29:8], int'(VECS[i][7:0]));
        end
        // R14 idle cycle with garbage inputs holds result and flags
        vld = 1'b0; ctl = 12'hFFF; src = 16'h5a5a; dst = 16'ha5a5; fin = 4'hF; bw = 1'b0;
        @(negedge clk);
        check({res, fl, wr, fen}, {16'h00cd, 4'h0, 1'b0, 1'b0}, 14);
        @(negedge clk);
        check({res, fl, wr, fen}, {16'h00cd, 4'h0, 1'b0, 1'b0}, 14);
        // R9 write suppressed while flags still update (sub with no-write)
        vld = 1'b1; ctl = 12'hA0B; src = 16'h0004; dst = 16'h0004; fin = 4'h0;
        @(negedge clk);
        check({res, fl, wr, fen}, {16'h0000, 4'h3, 1'b0, 1'b1}, 9);
        // R14 reset mid-run clears outputs
        vld = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check({res, fl, wr, fen}, 22'd0, 14);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule